// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one channel that hangs off a shared free-running time base. A seven-bit mode word decides what the channel does with the count it sees: it can latch the count when its pin changes (on a rising transition, a falling transition or both), flag the moment the count reaches a programmed value, toggle its output pin at that moment, or drive its pin as a pulse-width-modulated wave. A single register, loaded half by half, holds either the last captured count or the compare value.

Any capture or flagged match sets a sticky event flag. Only the flag-clear strobe resets it. The flag can be routed to an interrupt request. The time-base value is an input, so several channels can share one counter. The count may advance every clock or more slowly; a count that holds for several clocks still produces only one match.

Top module: `cc_channel`

## Requirements
- R1: After reset `event_flag` and `irq` are 0, `pin_out` is 1, `ccr_value` is 0 and every mode bit is 0.
- R2: With mode bit 5 set, a rising transition on `pin_in` copies `tb_count` into `ccr_value` and sets `event_flag`. Both take effect on the third rising clock edge after the pin changes; after the second edge the register still holds its old value.
- R3: With mode bit 4 set, a falling transition captures in the same way. With bits 4 and 5 both set, either transition captures. A transition whose bit is clear leaves `ccr_value` and `event_flag` unchanged.
- R4: With mode bits 6 and 3 set and PWM off, `event_flag` is set one clock after `tb_count` first equals `ccr_value`. A count value held for several clocks counts as one match.
- R5: With mode bit 6 clear, equality between `tb_count` and `ccr_value` neither sets the flag nor moves the pin.
- R6: With mode bits 6 and 2 set and PWM off, `pin_out` inverts one clock after each match. With no match it holds its value.
- R7: `event_flag` stays set until `flag_clr` is pulsed. If a capture or match occurs in the same clock as `flag_clr`, the flag stays set.
- R8: `irq` equals `event_flag` when mode bit 0 is set, and is 0 when it is clear.
- R9: With mode bits 6 and 1 set (PWM), `pin_out` one clock after a count is 0 when the low half of the count is below the low half of the register, and 1 otherwise.
- R10: In PWM mode, when the low half of `tb_count` steps from all ones to zero, the high half of the register is copied into the low half. The new duty applies starting at that zero count.
- R11: `wr_hi` and `wr_lo` load `wr_data` into the high and low halves of the register, visible on `ccr_value` one clock later. `wr_mode` loads `mode_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tb_count | input | CNT_W | Shared time-base value |
| pin_in | input | 1 | Asynchronous capture pin |
| wr_mode | input | 1 | Load the mode word |
| mode_wdata | input | 7 | New mode word |
| wr_hi | input | 1 | Load the high half of the register |
| wr_lo | input | 1 | Load the low half of the register |
| wr_data | input | CNT_W/2 | Data for a half-register write |
| flag_clr | input | 1 | Clear strobe for the event flag |
| pin_out | output | 1 | Channel output pin |
| event_flag | output | 1 | Sticky capture/match flag |
| irq | output | 1 | Interrupt request |
| ccr_value | output | CNT_W | Capture/compare register contents |

## Verification
The bench builds the channel with an 8-bit time base, so each half of the register is 4 bits wide. At that size every compare value can be reached by a full 256-step count sweep. Every PWM duty from 0 to 15 is checked against every count, at a cost of a few thousand cycles. Match sweeps are repeated with each count held for one clock and for three clocks, to show that a match fires only once per count value. Captures are checked for every combination of edge-enable bits and both pin directions, including the exact clock on which the captured value appears.

// File: rtl/cc_chan_pkg.sv
// Package: shared types for the capture/compare channel.
// The mode word bit positions are the software encoding and must not move.
package cc_chan_pkg;

    localparam int MODE_W = 7;

    // Mode word, MSB first: bit 6 compare enable ... bit 0 interrupt enable
    typedef struct packed {
        logic cmp_en;      // bit 6
        logic cap_rise;    // bit 5
        logic cap_fall;    // bit 4
        logic match_flag;  // bit 3
        logic toggle;      // bit 2
        logic pwm;         // bit 1
        logic irq_en;      // bit 0
    } cc_mode_t;

endpackage

// File: rtl/cc_pin_sync.sv
// Module: cc_pin_sync
// Brings an asynchronous pin into the clock domain through STAGES flops and
// reports single-cycle rising and falling pulses of the synchronised level.
// Assumes STAGES >= 2.
module cc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Purpose: shift chain for metastability plus one flop for edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Purpose: edge pulses from current versus previous synchronised level
    always_comb begin
        rise = sync_q[STAGES-1] & ~last_q;
        fall = ~sync_q[STAGES-1] & last_q;
    end

endmodule

// File: rtl/cc_ccr.sv
// Module: cc_ccr
// Capture/compare register held as two halves. Per half the priority is:
// software write, then capture, then (low half only) PWM reload from the high
// half. Assumes CNT_W is even.
module cc_ccr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic             cap_en,
    input  logic [CNT_W-1:0] cap_val,
    input  logic             reload,
    output logic [CNT_W-1:0] ccr
);

    localparam int HALF_W = CNT_W / 2;

    logic [HALF_W-1:0] hi_q;
    logic [HALF_W-1:0] lo_q;

    // Purpose: high half update
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_q <= '0;
        else if (wr_hi)   hi_q <= wr_data;
        else if (cap_en)  hi_q <= cap_val[CNT_W-1:HALF_W];
    end

    // Purpose: low half update, including the PWM duty reload
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_q <= '0;
        else if (wr_lo)   lo_q <= wr_data;
        else if (cap_en)  lo_q <= cap_val[HALF_W-1:0];
        else if (reload)  lo_q <= hi_q;
    end

    assign ccr = {hi_q, lo_q};

endmodule

// File: rtl/cc_cmp.sv
// Module: cc_cmp
// Compares the time base with the register. Produces a one-shot match pulse
// per entry into equality (so a held count matches once), a wrap pulse when
// the low half of the count steps from all ones to zero, and the PWM level
// using the duty that the wrap reload is about to install.
module cc_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] ccr,
    input  logic             cmp_en,
    output logic             hit,
    output logic             wrap,
    output logic             pwm_high
);

    localparam int HALF_W = CNT_W / 2;

    logic              eq;
    logic              eq_q;
    logic [HALF_W-1:0] prev_lo_q;
    logic [HALF_W-1:0] duty_eff;

    // Purpose: enabled equality and its one-shot edge
    always_comb begin
        eq  = cmp_en && (count == ccr);
        hit = eq && !eq_q;
    end

    // Purpose: remember last equality and last low half of the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_q      <= 1'b0;
            prev_lo_q <= '0;
        end else begin
            eq_q      <= eq;
            prev_lo_q <= count[HALF_W-1:0];
        end
    end

    // Purpose: wrap detection and PWM level against the effective duty
    always_comb begin
        wrap     = (prev_lo_q == {HALF_W{1'b1}}) && (count[HALF_W-1:0] == '0);
        duty_eff = wrap ? ccr[CNT_W-1:HALF_W] : ccr[HALF_W-1:0];
        pwm_high = (count[HALF_W-1:0] >= duty_eff);
    end

endmodule

// File: rtl/cc_channel.sv
// Module: cc_channel
// One capture/compare channel on a shared time base. Holds the mode word,
// the sticky event flag and the output pin; combines the synchroniser,
// comparator and register submodules. Assumes CNT_W even and SYNC_STAGES >= 2.
module cc_channel
    import cc_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     tb_count,
    input  logic                 pin_in,
    input  logic                 wr_mode,
    input  logic [MODE_W-1:0]    mode_wdata,
    input  logic                 wr_hi,
    input  logic                 wr_lo,
    input  logic [CNT_W/2-1:0]   wr_data,
    input  logic                 flag_clr,
    output logic                 pin_out,
    output logic                 event_flag,
    output logic                 irq,
    output logic [CNT_W-1:0]     ccr_value
);

    cc_mode_t mode_q;
    logic     rise, fall;
    logic     cap_evt, match_hit, wrap, pwm_high, pwm_act;
    logic     flag_set, toggle_now;
    logic     pin_q, flag_q;

    cc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall)
    );

    cc_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .count(tb_count), .ccr(ccr_value),
        .cmp_en(mode_q.cmp_en), .hit(match_hit), .wrap(wrap),
        .pwm_high(pwm_high)
    );

    cc_ccr #(.CNT_W(CNT_W)) u_ccr (
        .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .cap_en(cap_evt), .cap_val(tb_count),
        .reload(pwm_act && wrap), .ccr(ccr_value)
    );

    // Purpose: decode events from the mode word
    always_comb begin
        cap_evt    = (mode_q.cap_rise && rise) || (mode_q.cap_fall && fall);
        pwm_act    = mode_q.cmp_en && mode_q.pwm;
        flag_set   = cap_evt || (match_hit && mode_q.match_flag && !pwm_act);
        toggle_now = match_hit && mode_q.toggle && !pwm_act;
    end

    // Purpose: mode word register
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= cc_mode_t'(mode_wdata);
    end

    // Purpose: sticky event flag, hardware set wins over software clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (flag_set) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Purpose: output pin, PWM level or toggle on match; idles high
    always_ff @(posedge clk) begin
        if (!rst_n)          pin_q <= 1'b1;
        else if (pwm_act)    pin_q <= pwm_high;
        else if (toggle_now) pin_q <= ~pin_q;
    end

    assign pin_out    = pin_q;
    assign event_flag = flag_q;
    assign irq        = flag_q && mode_q.irq_en;

endmodule

// File: rtl/cc_channel_chk.sv
// Module: cc_channel_chk
// Property checker for cc_channel, attached by the bind below.
module cc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tb_count,
    input logic             wr_hi,
    input logic             wr_lo,
    input logic             flag_clr,
    input logic [6:0]       mode_bits,
    input logic             cap_evt,
    input logic             match_hit,
    input logic             pwm_act,
    input logic             pin_out,
    input logic             event_flag,
    input logic             irq,
    input logic [CNT_W-1:0] ccr_value
);

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        event_flag && !flag_clr |=> event_flag);

    p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(event_flag) |-> $past(cap_evt || match_hit));

    p_cap_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt && !wr_hi && !wr_lo |=> ccr_value == $past(tb_count));

    p_pin_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_act && !match_hit |=> $stable(pin_out));

    p_hit_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> !match_hit);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> event_flag && mode_bits[0]);

    p_no_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bits[6] |-> !match_hit);

endmodule

bind cc_channel cc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .wr_hi(wr_hi),
    .wr_lo(wr_lo), .flag_clr(flag_clr), .mode_bits(mode_q),
    .cap_evt(cap_evt), .match_hit(match_hit), .pwm_act(pwm_act),
    .pin_out(pin_out), .event_flag(event_flag), .irq(irq),
    .ccr_value(ccr_value)
);

// File: tb/sim_cc_channel.sv
module sim_cc_channel;

    localparam int CW = 8;
    localparam int HW = CW / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] tb_count = '0;
    logic          pin_in = 1'b0;
    logic          wr_mode = 1'b0;
    logic [6:0]    mode_wdata = '0;
    logic          wr_hi = 1'b0;
    logic          wr_lo = 1'b0;
    logic [HW-1:0] wr_data = '0;
    logic          flag_clr = 1'b0;
    logic          pin_out, event_flag, irq;
    logic [CW-1:0] ccr_value;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cc_channel #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .pin_in(pin_in),
        .wr_mode(wr_mode), .mode_wdata(mode_wdata), .wr_hi(wr_hi),
        .wr_lo(wr_lo), .wr_data(wr_data), .flag_clr(flag_clr),
        .pin_out(pin_out), .event_flag(event_flag), .irq(irq),
        .ccr_value(ccr_value)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [6:0] m);
        wr_mode = 1'b1; mode_wdata = m;
        cyc(1);
        wr_mode = 1'b0;
    endtask

    task automatic wr_reg(input logic [HW-1:0] hi, input logic [HW-1:0] lo);
        wr_hi = 1'b1; wr_data = hi;
        cyc(1);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = lo;
        cyc(1);
        wr_lo = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [6:0] cap_modes [4];
        logic [6:0] cmp_modes [4];
        cap_modes = '{7'h20, 7'h10, 7'h30, 7'h00};
        cmp_modes = '{7'h4D, 7'h44, 7'h49, 7'h0D};

        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk("R1 flag", event_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pin", pin_out, 1);
        chk("R1 ccr", ccr_value, 0);

        // R2/R3: capture for every edge-enable combination, both directions
        for (int mi = 0; mi < 4; mi++) begin
            logic [6:0] m;
            m = cap_modes[mi];
            set_mode(m);
            for (int i = 0; i < 8; i++) begin
                logic [CW-1:0] v, old;
                logic exp_cap;
                string tag;
                tag = (m == 7'h20) ? "R2" : "R3";
                v = CW'(i * 37 + mi * 11 + 1);
                tb_count = v;
                old = ccr_value;
                pin_in = ~pin_in;
                exp_cap = pin_in ? m[5] : m[4];
                cyc(2);
                chk("R2 timing ccr unchanged after two edges", ccr_value, old);
                cyc(1);
                chk({tag, " capture value"}, ccr_value, exp_cap ? v : old);
                chk({tag, " capture flag"}, event_flag, exp_cap);
                clr_flag();
                chk("R7 flag cleared", event_flag, 0);
            end
        end

        // R7: capture in the same clock as a clear keeps the flag
        set_mode(7'h30);
        tb_count = 8'h5A;
        pin_in = ~pin_in;
        cyc(3);
        chk("R7 flag set by capture", event_flag, 1);
        tb_count = 8'h3C;
        pin_in = ~pin_in;
        cyc(2);
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        chk("R7 set wins over clear", event_flag, 1);
        chk("R3 capture with clear", ccr_value, 8'h3C);
        clr_flag();
        chk("R7 clear alone", event_flag, 0);

        // R4/R5/R6/R8: compare sweeps over every count, holds of 1 and 3
        for (int mi = 0; mi < 4; mi++) begin
            logic [6:0] m;
            m = cmp_modes[mi];
            for (int c = 2; c < 256; c += 23) begin
                logic exp_pin, exp_flag, prev_eq;
                int hold;
                set_mode(7'h00);
                tb_count = CW'(c) ^ 8'h80;
                wr_reg(HW'(c >> HW), HW'(c));
                chk("R11 write", ccr_value, c);
                set_mode(m);
                clr_flag();
                exp_pin = pin_out;
                exp_flag = 1'b0;
                prev_eq = 1'b0;
                hold = (c % 2 == 1) ? 3 : 1;
                for (int k = 0; k < 256; k++) begin
                    for (int h = 0; h < hold; h++) begin
                        logic eq, hit;
                        tb_count = CW'(k);
                        cyc(1);
                        eq = m[6] && (k == c);
                        hit = eq && !prev_eq;
                        prev_eq = eq;
                        if (hit && m[2]) exp_pin = ~exp_pin;
                        if (hit && m[3]) exp_flag = 1'b1;
                        if (m[6]) begin
                            chk("R6 toggle pin", pin_out, exp_pin);
                            chk("R4 match flag", event_flag, exp_flag);
                        end else begin
                            chk("R5 disabled pin", pin_out, exp_pin);
                            chk("R5 disabled flag", event_flag, exp_flag);
                        end
                        chk("R8 irq", irq, exp_flag && m[0]);
                    end
                end
            end
        end

        // R9: every duty against every count
        for (int d = 0; d < 16; d++) begin
            set_mode(7'h00);
            wr_reg(HW'(d), HW'(d));
            chk("R11 write duty", ccr_value, d * 17);
            tb_count = '0;
            set_mode(7'h42);
            for (int k = 0; k < 256; k++) begin
                tb_count = CW'(k);
                cyc(1);
                chk("R9 pwm level", pin_out, (k % 16) >= d);
            end
        end

        // R10: high half reloads into low half at each low-half wrap
        begin
            int duty, hi_m, prev;
            set_mode(7'h00);
            wr_reg(HW'(12), HW'(3));
            tb_count = 8'h10;
            set_mode(7'h42);
            duty = 3;
            hi_m = 12;
            prev = 16;
            for (int k = 16; k < 96; k++) begin
                tb_count = CW'(k);
                if (k == 56) begin
                    wr_hi = 1'b1;
                    wr_data = HW'(5);
                end
                if ((prev % 16) == 15 && (k % 16) == 0) duty = hi_m;
                cyc(1);
                wr_hi = 1'b0;
                if (k == 56) hi_m = 5;
                chk("R10 pwm after reload", pin_out, (k % 16) >= duty);
                if (k == 32) chk("R10 low half reloaded", ccr_value % 16, 12);
                if (k == 64) chk("R10 second reload", ccr_value % 16, 5);
                prev = k;
            end
        end

        finish_run();
    end

endmodule